// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that has been left in an unknown state, for example by a target that stopped halfway through a byte. Once triggered, it halts the attached I2C engine and switches the two bus pins over to itself. It then drives a fixed, timed pattern on them. SCL goes high first, and SDA follows after a short delay. After a settling time SDA is pulled low while SCL stays high, which forms a start condition. SDA is later released, which forms a stop condition. Any target that sees a start followed by a stop drops its partial transfer.

At the end of the pattern the pins go back to the engine, and the engine is enabled again. In the same single cycle the engine gets a reset pulse, a clear pulse for its sticky status flags, and a done pulse.

There are two ways to start a recovery:
- **Explicit request:** a read-timeout or write-timeout request from the transfer logic.
- **Automatic:** a start request arriving while the bus is not idle, meaning the engine is busy, a status flag is pending, or either sampled line is low.

When a start request arrives on an idle bus, the block passes it through instead. A 2-bit code records the reason for the last recovery. All dwell times are given in microseconds and are measured with an internal prescaler of `CLK_PER_US` clocks per microsecond.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, the outputs are in their idle state: `busy`, `pin_sel`, `scl_drv`, `sda_drv`, `sda_val`, `eng_kill`, `eng_rst`, `status_clr` and `done` are 0, `eng_en` is 1, and `cause` is 0.
- R2: A start request while idle is handled according to the bus state:
  - On an idle bus (engine not busy, no status pending, both lines high) with no timeout request, `start_go` is 1 in that same cycle and no recovery starts.
  - When the bus is not idle for any one of those four reasons, a recovery starts.
- R3: An accepted trigger loads `cause` with one code: write timeout gives 3, read timeout gives 2, and start on a non-idle bus gives 1. The priority is 3 over 2 over 1, and the code holds until the next accepted trigger.
- R4: In the first cycle of a recovery, `eng_kill` is 1 for exactly one cycle. `busy` is 1 and `eng_en` is 0 from then on, and `pin_sel` is still 0 in that cycle.
- R5: The next `T_SCL_US*CLK_PER_US` cycles form the SCL phase: `pin_sel`=1, `scl_drv`=1 and `sda_drv`=0.
- R6: The next `T_SDA_US*CLK_PER_US` cycles drive SDA high: `sda_drv`=1 and `sda_val`=1, with SCL still driven.
- R7: The next `T_START_US*CLK_PER_US` cycles form the start condition: `sda_drv`=1 and `sda_val`=0, with SCL still driven high.
- R8: The next `T_STOP_US*CLK_PER_US` cycles form the stop condition: `sda_val`=1 again, with both lines still driven.
- R9: One final cycle has `pin_sel`=0, no line driven, `eng_en`=1, and `eng_rst`, `status_clr` and `done` all 1. In the following cycle the block is idle.
- R10: While a recovery runs, any new trigger or start request is ignored: `cause` is unchanged, the phase timing is unchanged, and `start_go` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | The engine is asking to begin a transfer |
| eng_busy | input | 1 | The engine reports a transfer in progress |
| status_pend | input | 1 | One or more sticky status flags of the engine are set |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| rd_tmo | input | 1 | Explicit recovery request after a read timed out |
| wr_tmo | input | 1 | Explicit recovery request after a write timed out |
| start_go | output | 1 | Start request accepted on an idle bus |
| busy | output | 1 | A recovery is in progress |
| pin_sel | output | 1 | 1 = the bus pins are driven by this block, 0 = by the engine |
| scl_drv | output | 1 | Drive SCL high |
| sda_drv | output | 1 | Drive SDA to `sda_val` |
| sda_val | output | 1 | Level driven on SDA |
| eng_en | output | 1 | Engine enable |
| eng_kill | output | 1 | Abort the transfer in progress in the engine |
| eng_rst | output | 1 | Reset pulse to the engine at the end |
| status_clr | output | 1 | Clear pulse for all sticky status flags |
| done | output | 1 | One-cycle pulse at the end of a recovery |
| cause | output | 2 | Reason code of the last recovery |

## Verification
The phase in which each fault becomes visible at the ports:
- **Prescaler or dwell counter fault:** a phase lasts too long or too short. This shows one cycle after the wrong boundary, as an early or late change of `sda_drv` or `sda_val`.
- **Sequencer that skips or repeats a phase:** this shows up as a wrong pin pattern within one phase length.
- **Sequencer that re-arms on a trigger during a run:** this alters `cause` or stretches the sequence. The bench checks the full output vector in every cycle while it drives random triggers into a running sequence.
- **Wrong priority in the trigger decode:** this shows in `cause` on the first cycle of the recovery.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_KILL     = 3'd1,
    ST_SCL_UP   = 3'd2,
    ST_SDA_UP   = 3'd3,
    ST_SDA_LOW  = 3'd4,
    ST_SDA_REL  = 3'd5,
    ST_FIN      = 3'd6
  } rcv_state_e;

  typedef enum logic [1:0] {
    CZ_NONE     = 2'd0,
    CZ_NOT_IDLE = 2'd1,
    CZ_RD_TMO   = 2'd2,
    CZ_WR_TMO   = 2'd3
  } rcv_cause_e;

  // R3: write timeout outranks read timeout, which outranks non-idle start
  function automatic rcv_cause_e pick_cause(input logic wr, input logic rd,
                                            input logic busy_start);
    if (wr)              return CZ_WR_TMO;
    else if (rd)         return CZ_RD_TMO;
    else if (busy_start) return CZ_NOT_IDLE;
    else                 return CZ_NONE;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int width_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rcv_trigger.sv
module rcv_trigger
  import i2c_rcv_pkg::*;
(
  input  logic       armed,
  input  logic       start_req,
  input  logic       eng_busy,
  input  logic       status_pend,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       rd_tmo,
  input  logic       wr_tmo,
  output logic       fire,
  output rcv_cause_e cause_nxt,
  output logic       start_go
);
  logic not_idle;
  logic busy_start;

  always_comb begin
    not_idle   = eng_busy | status_pend | ~scl_in | ~sda_in;
    busy_start = start_req & not_idle;
    fire       = armed & (busy_start | rd_tmo | wr_tmo);
    cause_nxt  = pick_cause(wr_tmo, rd_tmo, busy_start);
    start_go   = armed & start_req & ~not_idle & ~rd_tmo & ~wr_tmo;
  end
endmodule

// File: rtl/rcv_dwell_timer.sv
module rcv_dwell_timer
  import i2c_rcv_pkg::*;
#(
  parameter int CLK_PER_US = 48,
  parameter int US_W       = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [US_W-1:0] target_us,
  output logic            expire
);
  localparam int PRE_W = width_for(CLK_PER_US);
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre;
  logic [US_W-1:0]  us_cnt;
  logic             us_tick;

  assign us_tick = (pre == PRE_MAX);
  assign expire  = us_tick && (us_cnt == target_us - US_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pre    <= '0;
      us_cnt <= '0;
    end else if (us_tick) begin
      pre    <= '0;
      us_cnt <= us_cnt + US_W'(1);
    end else begin
      pre    <= pre + PRE_W'(1);
    end
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= PRE_MAX); // R5
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import i2c_rcv_pkg::*;
#(
  parameter int CLK_PER_US = 48,
  parameter int T_SCL_US   = 16,
  parameter int T_SDA_US   = 500,
  parameter int T_START_US = 1000,
  parameter int T_STOP_US  = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       eng_busy,
  input  logic       status_pend,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       rd_tmo,
  input  logic       wr_tmo,
  output logic       start_go,
  output logic       busy,
  output logic       pin_sel,
  output logic       scl_drv,
  output logic       sda_drv,
  output logic       sda_val,
  output logic       eng_en,
  output logic       eng_kill,
  output logic       eng_rst,
  output logic       status_clr,
  output logic       done,
  output logic [1:0] cause
);
  localparam int MAX_US = max4(T_SCL_US, T_SDA_US, T_START_US, T_STOP_US);
  localparam int US_W   = width_for(MAX_US + 1);

  rcv_state_e      state, state_nxt;
  rcv_cause_e      cause_q, cause_nxt;
  logic            fire, in_dwell, expire, tmr_clr;
  logic [US_W-1:0] target_us;

  rcv_trigger u_trig (
    .armed      (state == ST_IDLE),
    .start_req  (start_req),
    .eng_busy   (eng_busy),
    .status_pend(status_pend),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .rd_tmo     (rd_tmo),
    .wr_tmo     (wr_tmo),
    .fire       (fire),
    .cause_nxt  (cause_nxt),
    .start_go   (start_go)
  );

  assign in_dwell = (state == ST_SCL_UP) || (state == ST_SDA_UP) ||
                    (state == ST_SDA_LOW) || (state == ST_SDA_REL);
  assign tmr_clr  = !in_dwell || expire;

  always_comb begin
    case (state)
      ST_SCL_UP:  target_us = US_W'(T_SCL_US);
      ST_SDA_UP:  target_us = US_W'(T_SDA_US);
      ST_SDA_LOW: target_us = US_W'(T_START_US);
      default:    target_us = US_W'(T_STOP_US);
    endcase
  end

  rcv_dwell_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .target_us(target_us),
    .expire   (expire)
  );

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:    if (fire)   state_nxt = ST_KILL;
      ST_KILL:                state_nxt = ST_SCL_UP;
      ST_SCL_UP:  if (expire) state_nxt = ST_SDA_UP;
      ST_SDA_UP:  if (expire) state_nxt = ST_SDA_LOW;
      ST_SDA_LOW: if (expire) state_nxt = ST_SDA_REL;
      ST_SDA_REL: if (expire) state_nxt = ST_FIN;
      default:                state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cause_q <= CZ_NONE;
    end else begin
      state <= state_nxt;
      if (fire) cause_q <= cause_nxt;
    end
  end

  always_comb begin
    busy       = (state != ST_IDLE);
    pin_sel    = in_dwell;
    scl_drv    = in_dwell;
    sda_drv    = (state == ST_SDA_UP) || (state == ST_SDA_LOW) || (state == ST_SDA_REL);
    sda_val    = (state == ST_SDA_UP) || (state == ST_SDA_REL);
    eng_en     = (state == ST_IDLE) || (state == ST_FIN);
    eng_kill   = (state == ST_KILL);
    eng_rst    = (state == ST_FIN);
    status_clr = (state == ST_FIN);
    done       = (state == ST_FIN);
    cause      = cause_q;
  end

  AST_KILL_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> eng_kill); // R4
  AST_KILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_kill |=> !eng_kill && busy); // R4
  AST_ENGINE_OFF_ON_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sel |-> !eng_en); // R5
  AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drv && !sda_val) |-> scl_drv); // R7
  AST_STOP_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sda_drv) && !$past(sda_val) && !(sda_drv && !sda_val)) |-> (sda_drv && sda_val)); // R8
  AST_REENABLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_en) |-> done && eng_rst && status_clr); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R9
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cause)); // R10
  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_go); // R10
endmodule

// File: tb/tb_i2c_bus_recover.sv
module tb_i2c_bus_recover;
  localparam int C  = 3;
  localparam int T1 = 2;
  localparam int T2 = 4;
  localparam int T3 = 5;
  localparam int T4 = 3;
  localparam int A1 = 1 + T1 * C;
  localparam int A2 = A1 + T2 * C;
  localparam int A3 = A2 + T3 * C;
  localparam int A4 = A3 + T4 * C;
  localparam int SEQ_LEN = A4 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, eng_busy = 1'b0, status_pend = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, rd_tmo = 1'b0, wr_tmo = 1'b0;
  logic start_go, busy, pin_sel, scl_drv, sda_drv, sda_val;
  logic eng_en, eng_kill, eng_rst, status_clr, done;
  logic [1:0] cause;

  int n_tests = 0;
  int n_fail  = 0;
  logic [1:0] held_cause = 2'd0;

  always #4 clk = ~clk;

  i2c_bus_recover #(.CLK_PER_US(C), .T_SCL_US(T1), .T_SDA_US(T2),
                    .T_START_US(T3), .T_STOP_US(T4)) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .eng_busy(eng_busy),
    .status_pend(status_pend), .scl_in(scl_in), .sda_in(sda_in),
    .rd_tmo(rd_tmo), .wr_tmo(wr_tmo), .start_go(start_go), .busy(busy),
    .pin_sel(pin_sel), .scl_drv(scl_drv), .sda_drv(sda_drv), .sda_val(sda_val),
    .eng_en(eng_en), .eng_kill(eng_kill), .eng_rst(eng_rst),
    .status_clr(status_clr), .done(done), .cause(cause));

  // vector order: busy pin_sel scl_drv sda_drv sda_val eng_en eng_kill eng_rst status_clr done
  function automatic logic [9:0] outs_now();
    return {busy, pin_sel, scl_drv, sda_drv, sda_val, eng_en, eng_kill, eng_rst, status_clr, done};
  endfunction

  localparam logic [9:0] V_IDLE = 10'b0000010000;

  function automatic logic [9:0] exp_vec(input int k);
    if (k == 0)       return 10'b1000001000; // kill, engine off
    else if (k < A1)  return 10'b1110000000; // SCL high only
    else if (k < A2)  return 10'b1111100000; // both high
    else if (k < A3)  return 10'b1111000000; // SDA low: start
    else if (k < A4)  return 10'b1111100000; // SDA released: stop
    else              return 10'b1000010111; // hand back
  endfunction

  function automatic string req_of(input int k);
    if (k == 0)      return "R4";
    else if (k < A1) return "R5";
    else if (k < A2) return "R6";
    else if (k < A3) return "R7";
    else if (k < A4) return "R8";
    else             return "R9";
  endfunction

  function automatic logic [1:0] exp_cause(input logic sr, input logic b, input logic p,
                                           input logic scl, input logic sda,
                                           input logic rd, input logic wr);
    logic dirty;
    dirty = b || p || (scl == 1'b0) || (sda == 1'b0);
    case ({wr, rd})
      2'b10, 2'b11: return 2'd3;
      2'b01:        return 2'd2;
      default:      return (sr && dirty) ? 2'd1 : 2'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet();
    start_req = 0; eng_busy = 0; status_pend = 0; scl_in = 1; sda_in = 1; rd_tmo = 0; wr_tmo = 0;
  endtask

  task automatic noise();
    start_req = 1'($urandom); eng_busy = 1'($urandom); status_pend = 1'($urandom);
    scl_in = 1'($urandom); sda_in = 1'($urandom);
    rd_tmo = 1'($urandom); wr_tmo = 1'($urandom);
  endtask

  // inputs already driven at a negedge; follows the whole recovery
  task automatic run_seq(input logic [1:0] ec, input bit noisy);
    for (int k = 0; k < SEQ_LEN; k++) begin
      @(negedge clk);
      chk(req_of(k), 32'(outs_now()), 32'(exp_vec(k)));
      if (k == 0) chk("R3", 32'(cause), 32'(ec));
      if (k < SEQ_LEN - 1 && noisy) begin
        noise();
        #1 chk("R10", 32'(start_go), 32'd0);
      end else quiet();
    end
    @(negedge clk);
    chk("R9", 32'(outs_now()), 32'(V_IDLE));
    chk("R10", 32'(cause), 32'(ec));
    held_cause = ec;
  endtask

  task automatic try_trigger(input logic sr, input logic b, input logic p, input logic scl,
                             input logic sda, input logic rd, input logic wr, input bit noisy);
    logic [1:0] ec;
    logic bus_ok;
    start_req = sr; eng_busy = b; status_pend = p; scl_in = scl; sda_in = sda;
    rd_tmo = rd; wr_tmo = wr;
    ec = exp_cause(sr, b, p, scl, sda, rd, wr);
    bus_ok = !b && !p && scl && sda;
    #1;
    chk("R2", 32'(start_go), 32'(sr && bus_ok && !rd && !wr));
    if (ec != 2'd0) run_seq(ec, noisy);
    else begin
      @(negedge clk);
      chk("R2", 32'(outs_now()), 32'(V_IDLE));
      chk("R3", 32'(cause), 32'(held_cause));
      quiet();
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    quiet();
    repeat (3) @(negedge clk);
    chk("R1", 32'(outs_now()), 32'(V_IDLE));
    chk("R1", 32'(cause), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(outs_now()), 32'(V_IDLE));
    // R2: idle bus start passes through, then each non-idle reason
    try_trigger(1, 0, 0, 1, 1, 0, 0, 0);
    try_trigger(1, 1, 0, 1, 1, 0, 0, 0);
    try_trigger(1, 0, 1, 1, 1, 0, 0, 0);
    try_trigger(1, 0, 0, 0, 1, 0, 0, 0);
    try_trigger(1, 0, 0, 1, 0, 0, 0, 0);
    // no start request on a dirty bus: nothing happens
    try_trigger(0, 1, 1, 0, 0, 0, 0, 0);
    // R3 priority corners
    try_trigger(0, 0, 0, 1, 1, 1, 0, 0);
    try_trigger(0, 0, 0, 1, 1, 0, 1, 0);
    try_trigger(1, 1, 1, 0, 0, 1, 1, 0);
    try_trigger(1, 0, 0, 1, 1, 1, 0, 0);
    // R10: triggers hammered during a run
    try_trigger(0, 0, 0, 1, 1, 1, 0, 1);
    for (int i = 0; i < 40; i++) begin
      try_trigger(1'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
                  1'($urandom % 5 != 0), 1'($urandom % 5 != 0),
                  1'($urandom % 4 == 0), 1'($urandom % 4 == 0), 1'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule